// File: doc/BRIEF.md
# Two-Requester Shared Word Memory Controller

This controller lets two independent bus masters share one single-port memory array, so that each of them sees what looks like its own private 8K-word memory. A host master talks to it through an asynchronous strobe/reply handshake. A 16-bit processor talks to it through a synchronous request/acknowledge pair. Toward the array, the controller behaves as one user that issues a single access at a time and gets its read data back after a fixed latency.

Inside the block, a round-robin arbiter picks which master is served next. A sequencer holds the granted master's address, direction and data steady for the whole array access and returns the read word to that master. The array cells are 20 bits wide, but only the low 16 bits carry data. Only whole 16-bit words are moved: byte selection and split read-pause-write cycles requested by the host are ignored. The host strobe is asynchronous to the controller clock, so it is synchronised before the controller samples it.

Top module: `twin_master_mem_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `hb_ssyn`, `hb_doe`, `cp_ack` and `mem_req` are all low.
- R2: A host write (`hb_c1` = 1) stores `hb_din` into the cell indexed by `hb_addr[13:1]`, and `mem_wdata[19:16]` is zero. The byte-select bit `hb_addr[0]` and the split-cycle line `hb_c0` have no effect: the same word is written whatever their values.
- R3: A host read (`hb_c1` = 0) returns bits [15:0] of the addressed cell on `hb_dout`, whatever the cell's top 4 bits hold. `hb_dout` already holds that value one cycle before `hb_ssyn` rises. `hb_doe` is high only while `hb_ssyn` is high during a read.
- R4: Once raised, `hb_ssyn` stays high for as long as `hb_msyn` stays high. It falls on the third rising clock edge after `hb_msyn` goes low.
- R5: The processor holds `cp_req`, `cp_we` (1 = write), `cp_addr` and `cp_wdata` until `cp_ack`. `cp_ack` is a single-cycle pulse. On a read, `cp_rdata` carries bits [15:0] of the addressed cell while `cp_ack` is high.
- R6: When both masters present a request at the same edge and it is the host's turn, the host is served first. The host has the turn after reset.
- R7: Priority alternates. After a host grant, a tie goes to the processor. After a processor grant, a tie goes to the host.
- R8: Each access raises `mem_req` for exactly one cycle. `mem_addr`, `mem_we` and `mem_wdata` stay stable until that access completes, and no second `mem_req` is issued before then.
- R9: `mem_rdata` is sampled exactly `MEM_LAT` rising edges after the edge at which `mem_req` is first seen high. A processor access to an idle controller gets `cp_ack` `MEM_LAT`+2 cycles after `cp_req` is first sampled.
- R10: `hb_msyn` passes through a two-flop synchroniser. A host access to an idle controller raises `mem_req` in the fourth cycle after `hb_msyn` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_msyn | input | 1 | Host master strobe, asynchronous |
| hb_addr | input | 14 | Host byte address; bit 0 ignored, bits 13:1 select the word |
| hb_c1 | input | 1 | Host direction: 1 write, 0 read |
| hb_c0 | input | 1 | Host split-cycle request, ignored |
| hb_din | input | 16 | Host write data (inbound half of the data lines) |
| hb_dout | output | 16 | Host read data (outbound half of the data lines) |
| hb_doe | output | 1 | Drive enable for `hb_dout` |
| hb_ssyn | output | 1 | Slave reply to the host strobe |
| cp_req | input | 1 | Processor request, held until acknowledged |
| cp_we | input | 1 | Processor direction: 1 write, 0 read |
| cp_addr | input | 13 | Processor word address |
| cp_wdata | input | 16 | Processor write data |
| cp_rdata | output | 16 | Processor read data, valid with `cp_ack` |
| cp_ack | output | 1 | Processor completion pulse |
| mem_req | output | 1 | Array access issue pulse |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 13 | Array word address |
| mem_wdata | output | 20 | Array write data, top 4 bits zero |
| mem_rdata | input | 20 | Array read data, top 4 bits ignored |

## Verification
Each result has a fixed due cycle, counted in falling edges from the stimulus:
- `mem_req` on an idle controller: four edges after the host strobe rises.
- `hb_ssyn` release: three edges after the strobe drops.
- `cp_ack`: `MEM_LAT`+2 edges after the processor request.

The bench counts edges up to those points and compares the counts. The array model answers with valid data for exactly one cycle, with junk in the top nibble and elsewhere. A read sampled one cycle early or late therefore shows up as a data mismatch in the scoreboard. Priority is checked on ties that are placed at one edge: the host strobe is timed so that its synchronised request meets a processor request raised three cycles later. The first address that reaches the array shows which master won.

// File: rtl/twin_mem_pkg.sv
`timescale 1ns/1ps
package twin_mem_pkg;

  parameter int unsigned WORD_W  = 16;
  parameter int unsigned CELL_W  = 20;
  parameter int unsigned WADDR_W = 13;

  typedef enum logic [1:0] {HS_IDLE, HS_WAIT, HS_PRES, HS_ACK} hs_state_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_BUSY, SQ_DONE} sq_state_e;

  // host is chosen when it asks and either the cpu is silent or it is not the cpu's turn
  function automatic logic host_takes(input logic h, input logic c, input logic cpu_turn);
    return h && (!c || !cpu_turn);
  endfunction

  // widen a data word to an array cell with the spare top bits cleared
  function automatic logic [CELL_W-1:0] pad_cell(input logic [WORD_W-1:0] w);
    return {{(CELL_W-WORD_W){1'b0}}, w};
  endfunction

  // fixed-latency completion test
  function automatic logic lat_reached(input int unsigned cnt, input int unsigned lat);
    return cnt == lat;
  endfunction

endpackage

// File: rtl/strobe_sync.sv
`timescale 1ns/1ps
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/host_port.sv
`timescale 1ns/1ps
module host_port
  import twin_mem_pkg::*;
#(
  parameter int unsigned AW = WADDR_W,
  parameter int unsigned DW = WORD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msyn_async,
  input  logic [AW:0]   byte_addr,
  input  logic          dir_wr,
  input  logic          split_req,
  input  logic [DW-1:0] wr_word,
  input  logic          xfer_done,
  input  logic [DW-1:0] rd_word,
  output logic          acc_req,
  output logic          acc_we,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  output logic          ssyn,
  output logic [DW-1:0] dout,
  output logic          doe
);
  hs_state_e     state;
  logic          msyn_s;
  logic          we_q;
  logic [DW-1:0] dout_q;
  logic          ignored_unused;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (msyn_async),
    .q_sync  (msyn_s)
  );

  // byte select and split-cycle line carry no meaning for word-only transfers
  assign ignored_unused = ^{byte_addr[0], split_req};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= HS_IDLE;
      we_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      case (state)
        HS_IDLE: if (msyn_s) begin
          we_q  <= dir_wr;
          state <= HS_WAIT;
        end
        HS_WAIT: if (xfer_done) begin
          if (!we_q) dout_q <= rd_word;
          state <= HS_PRES;
        end
        HS_PRES: state <= HS_ACK;
        HS_ACK:  if (!msyn_s) state <= HS_IDLE;
        default: state <= HS_IDLE;
      endcase
    end
  end

  assign acc_req   = (state == HS_WAIT);
  assign acc_we    = we_q;
  assign acc_addr  = byte_addr[AW:1];
  assign acc_wdata = wr_word;
  assign ssyn      = (state == HS_ACK);
  assign doe       = (state == HS_ACK) && !we_q;
  assign dout      = dout_q;

  a_r3_drive_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> (ssyn && !acc_we));
  a_r3_data_before_reply: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssyn) |-> $stable(dout));
  a_r4_reply_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ssyn && msyn_s) |=> ssyn);
  a_r10_no_early_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_req) |-> $past(msyn_s));
endmodule

// File: rtl/rr_arb.sv
`timescale 1ns/1ps
module rr_arb
  import twin_mem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic req_h,
  input  logic req_c,
  output logic gnt_h,
  output logic gnt_c
);
  logic cpu_turn;

  assign gnt_h = take && host_takes(req_h, req_c, cpu_turn);
  assign gnt_c = take && req_c && !host_takes(req_h, req_c, cpu_turn);

  always_ff @(posedge clk) begin
    if (!rst_n)     cpu_turn <= 1'b0;
    else if (gnt_h) cpu_turn <= 1'b1;
    else if (gnt_c) cpu_turn <= 1'b0;
  end

  a_r6_host_on_tie: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_h && req_c && !cpu_turn) |-> gnt_h);
  a_r7_cpu_on_tie: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_h && req_c && cpu_turn) |-> gnt_c);
  a_r7_turn_passes: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_h |=> cpu_turn);
  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_h, gnt_c}));
endmodule

// File: rtl/mem_seq.sv
`timescale 1ns/1ps
module mem_seq
  import twin_mem_pkg::*;
#(
  parameter int unsigned AW  = WADDR_W,
  parameter int unsigned DW  = WORD_W,
  parameter int unsigned MW  = CELL_W,
  parameter int unsigned LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gnt_h,
  input  logic          gnt_c,
  input  logic [AW-1:0] h_addr,
  input  logic          h_we,
  input  logic [DW-1:0] h_wdata,
  input  logic [AW-1:0] c_addr,
  input  logic          c_we,
  input  logic [DW-1:0] c_wdata,
  input  logic [MW-1:0] mem_rdata,
  output logic          take,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [MW-1:0] mem_wdata,
  output logic [DW-1:0] rd_q,
  output logic          done_h,
  output logic          done_c
);
  localparam int unsigned CNT_W = $clog2(LAT + 1);

  sq_state_e      state;
  logic           owner_h;
  logic [CNT_W-1:0] cnt;
  logic           lat_hit;
  logic           ignored_unused;

  assign ignored_unused = ^mem_rdata[MW-1:DW];
  assign take    = (state == SQ_IDLE);
  assign lat_hit = (state == SQ_BUSY) && lat_reached(32'(cnt), LAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      owner_h   <= 1'b0;
      cnt       <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_q      <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (gnt_h || gnt_c) begin
            owner_h   <= gnt_h;
            mem_addr  <= gnt_h ? h_addr : c_addr;
            mem_we    <= gnt_h ? h_we : c_we;
            mem_wdata <= pad_cell(gnt_h ? h_wdata : c_wdata);
            mem_req   <= 1'b1;
            cnt       <= '0;
            state     <= SQ_BUSY;
          end
        end
        SQ_BUSY: begin
          mem_req <= 1'b0;
          cnt     <= CNT_W'(cnt + 1'b1);
          if (lat_hit) begin
            if (!mem_we) rd_q <= mem_rdata[DW-1:0];
            state <= SQ_DONE;
          end
        end
        SQ_DONE: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign done_h = (state == SQ_DONE) && owner_h;
  assign done_c = (state == SQ_DONE) && !owner_h;

  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r8_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !mem_req && $past(!take)) |-> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !(done_h || done_c));
  a_r2_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_wdata[MW-1:DW] == '0));
endmodule

// File: rtl/twin_master_mem_ctrl.sv
`timescale 1ns/1ps
module twin_master_mem_ctrl
  import twin_mem_pkg::*;
#(
  parameter int unsigned MEM_LAT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hb_msyn,
  input  logic [WADDR_W:0]   hb_addr,
  input  logic               hb_c1,
  input  logic               hb_c0,
  input  logic [WORD_W-1:0]  hb_din,
  output logic [WORD_W-1:0]  hb_dout,
  output logic               hb_doe,
  output logic               hb_ssyn,
  input  logic               cp_req,
  input  logic               cp_we,
  input  logic [WADDR_W-1:0] cp_addr,
  input  logic [WORD_W-1:0]  cp_wdata,
  output logic [WORD_W-1:0]  cp_rdata,
  output logic               cp_ack,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [CELL_W-1:0]  mem_wdata,
  input  logic [CELL_W-1:0]  mem_rdata
);
  logic               h_req, h_we;
  logic [WADDR_W-1:0] h_addr;
  logic [WORD_W-1:0]  h_wdata;
  logic               take, gnt_h, gnt_c, done_h, done_c;
  logic [WORD_W-1:0]  rd_q;

  host_port #(.AW(WADDR_W), .DW(WORD_W), .SYNC_STAGES(2)) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .msyn_async (hb_msyn),
    .byte_addr  (hb_addr),
    .dir_wr     (hb_c1),
    .split_req  (hb_c0),
    .wr_word    (hb_din),
    .xfer_done  (done_h),
    .rd_word    (rd_q),
    .acc_req    (h_req),
    .acc_we     (h_we),
    .acc_addr   (h_addr),
    .acc_wdata  (h_wdata),
    .ssyn       (hb_ssyn),
    .dout       (hb_dout),
    .doe        (hb_doe)
  );

  rr_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .req_h (h_req),
    .req_c (cp_req),
    .gnt_h (gnt_h),
    .gnt_c (gnt_c)
  );

  mem_seq #(.AW(WADDR_W), .DW(WORD_W), .MW(CELL_W), .LAT(MEM_LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_h     (gnt_h),
    .gnt_c     (gnt_c),
    .h_addr    (h_addr),
    .h_we      (h_we),
    .h_wdata   (h_wdata),
    .c_addr    (cp_addr),
    .c_we      (cp_we),
    .c_wdata   (cp_wdata),
    .mem_rdata (mem_rdata),
    .take      (take),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rd_q      (rd_q),
    .done_h    (done_h),
    .done_c    (done_c)
  );

  assign cp_ack   = done_c;
  assign cp_rdata = rd_q;

  a_r5_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cp_ack |=> !cp_ack);
  a_r5_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(h_req || cp_req));
endmodule

// File: tb/twin_master_mem_ctrl_bench.sv
`timescale 1ns/1ps
module twin_master_mem_ctrl_bench;
  localparam int unsigned LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hb_msyn = 1'b0;
  logic [13:0] hb_addr = '0;
  logic        hb_c1 = 1'b0, hb_c0 = 1'b0;
  logic [15:0] hb_din = '0;
  logic [15:0] hb_dout;
  logic        hb_doe, hb_ssyn;
  logic        cp_req = 1'b0, cp_we = 1'b0;
  logic [12:0] cp_addr = '0;
  logic [15:0] cp_wdata = '0;
  logic [15:0] cp_rdata;
  logic        cp_ack;
  logic        mem_req, mem_we;
  logic [12:0] mem_addr;
  logic [19:0] mem_wdata;
  logic [19:0] mem_rdata = 20'hF0BAD;

  int checks = 0;
  int fails  = 0;

  typedef struct { bit rd; logic [15:0] d; } exp_t;
  exp_t hq[$];
  exp_t cq[$];
  logic [15:0] shadow [int unsigned];
  logic [19:0] cells  [int unsigned];
  logic [12:0] mem_log[$];

  always #2.5 clk = ~clk;

  twin_master_mem_ctrl #(.MEM_LAT(LAT)) u_twin_master_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .hb_msyn(hb_msyn), .hb_addr(hb_addr), .hb_c1(hb_c1),
    .hb_c0(hb_c0), .hb_din(hb_din), .hb_dout(hb_dout), .hb_doe(hb_doe), .hb_ssyn(hb_ssyn),
    .cp_req(cp_req), .cp_we(cp_we), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
    .cp_rdata(cp_rdata), .cp_ack(cp_ack), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sh_rd(input logic [12:0] a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] cell_rd(input logic [12:0] a);
    return cells.exists(a) ? cells[a][15:0] : 16'h0000;
  endfunction

  // array model: one-cycle valid read window, junk outside it and in the top nibble
  logic [12:0] cap_addr = '0;
  int unsigned lat_cnt = 0;
  always @(posedge clk) begin : array_model
    int unsigned nxt;
    if (mem_req) begin
      nxt = 1;
      cap_addr = mem_addr;
      mem_log.push_back(mem_addr);
      if (mem_we) begin
        cells[mem_addr] = mem_wdata;
        chk(mem_wdata[19:16] == 4'h0, "R2", "array top bits on write", 32'(mem_wdata[19:16]), 0);
      end
    end else if (lat_cnt == LAT) nxt = 0;
    else if (lat_cnt != 0) nxt = lat_cnt + 1;
    else nxt = 0;
    if (lat_cnt != 0 && !mem_req && mem_addr != cap_addr)
      chk(0, "R8", "array address moved mid-access", 32'(mem_addr), 32'(cap_addr));
    lat_cnt = nxt;
    mem_rdata <= (nxt == LAT) ? {4'hA, cell_rd(cap_addr)} : 20'hF0BAD;
  end

  // scoreboard monitor
  logic ssyn_prev = 1'b0, ack_prev = 1'b0;
  logic [15:0] dout_prev = '0;
  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_n) begin
      if (hb_ssyn && !ssyn_prev) begin
        if (hq.size() == 0) chk(0, "R3", "reply with nothing pending", 1, 0);
        else begin
          e = hq.pop_front();
          if (e.rd) begin
            chk(hb_dout == e.d, "R3", "host read data", 32'(hb_dout), 32'(e.d));
            chk(hb_doe, "R3", "drive enable during read reply", 32'(hb_doe), 1);
            chk(hb_dout == dout_prev, "R3", "data settled before reply", 32'(dout_prev), 32'(hb_dout));
          end else chk(!hb_doe, "R3", "no drive on write reply", 32'(hb_doe), 0);
        end
      end
      if (hb_doe && !hb_ssyn) chk(0, "R3", "drive without reply", 1, 0);
      if (cp_ack) begin
        chk(!ack_prev, "R5", "ack longer than one cycle", 32'(ack_prev), 0);
        if (!ack_prev) begin
          if (cq.size() == 0) chk(0, "R5", "ack with nothing pending", 1, 0);
          else begin
            e = cq.pop_front();
            if (e.rd) chk(cp_rdata == e.d, "R5", "cpu read data", 32'(cp_rdata), 32'(e.d));
          end
        end
      end
    end
    ssyn_prev = hb_ssyn;
    ack_prev  = cp_ack;
    dout_prev = hb_dout;
  end

  task automatic host_acc(input logic [12:0] a, input bit wr, input logic [15:0] d,
                          input bit a0, input bit c0, input bit timed);
    int n;
    @(negedge clk);
    hb_addr = {a, a0}; hb_c1 = wr; hb_c0 = c0; hb_din = d;
    hq.push_back('{rd: !wr, d: wr ? 16'h0 : sh_rd(a)});
    if (wr) shadow[a] = d;
    hb_msyn = 1'b1;
    n = 0;
    if (timed) begin
      while (!mem_req) begin @(negedge clk); n++; end
      chk(n == 4, "R10", "strobe to array request cycles", 32'(n), 4);
    end
    while (!hb_ssyn) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk(hb_ssyn, "R4", "reply held while strobe high", 32'(hb_ssyn), 1);
    end
    hb_msyn = 1'b0;
    n = 0;
    while (hb_ssyn) begin @(negedge clk); n++; end
    if (timed) chk(n == 3, "R4", "strobe drop to reply drop cycles", 32'(n), 3);
  endtask

  task automatic cpu_acc(input logic [12:0] a, input bit wr, input logic [15:0] d,
                         input bit timed);
    int n;
    @(negedge clk);
    cp_addr = a; cp_we = wr; cp_wdata = d;
    cq.push_back('{rd: !wr, d: wr ? 16'h0 : sh_rd(a)});
    if (wr) shadow[a] = d;
    cp_req = 1'b1;
    n = 0;
    while (!cp_ack) begin @(negedge clk); n++; end
    if (timed) chk(n == LAT + 2, "R9", "request to ack cycles", 32'(n), 32'(LAT + 2));
    cp_req = 1'b0;
  endtask

  task automatic run_tests();
    // R1: reset state
    repeat (4) @(negedge clk);
    chk(!hb_ssyn && !hb_doe && !cp_ack && !mem_req, "R1", "outputs in reset",
        32'({hb_ssyn, hb_doe, cp_ack, mem_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hb_ssyn && !hb_doe && !cp_ack && !mem_req, "R1", "outputs after reset",
        32'({hb_ssyn, hb_doe, cp_ack, mem_req}), 0);

    // R2, R10: plain host write
    host_acc(13'h0123, 1'b1, 16'hBEEF, 1'b0, 1'b0, 1'b1);
    chk(cell_rd(13'h0123) == 16'hBEEF, "R2", "host write lands", 32'(cell_rd(13'h0123)), 32'hBEEF);
    // R2: byte bit and split-cycle line ignored
    host_acc(13'h1FFF, 1'b1, 16'h1357, 1'b1, 1'b1, 1'b1);
    chk(cell_rd(13'h1FFF) == 16'h1357, "R2", "write with byte/split set", 32'(cell_rd(13'h1FFF)), 32'h1357);
    cpu_acc(13'h1FFF, 1'b0, 16'h0, 1'b1);
    // R3, R4: host read
    host_acc(13'h0123, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    host_acc(13'h1FFF, 1'b0, 16'h0, 1'b1, 1'b1, 1'b1);
    // R5, R9: cpu write then read
    cpu_acc(13'h0000, 1'b1, 16'hA5A5, 1'b1);
    cpu_acc(13'h0000, 1'b0, 16'h0, 1'b1);
    repeat (2) @(negedge clk);

    // R6: tie with host turn (last grant went to cpu)
    mem_log.delete();
    fork
      host_acc(13'h0123, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
      begin repeat (3) @(negedge clk); cpu_acc(13'h0000, 1'b0, 16'h0, 1'b0); end
    join
    chk(mem_log.size() == 2, "R8", "one array request per access", 32'(mem_log.size()), 2);
    chk(mem_log[0] == 13'h0123, "R6", "host first on tie", 32'(mem_log[0]), 32'h0123);

    // R7: lone host grant passes the turn to the cpu
    host_acc(13'h0456, 1'b1, 16'h0F0F, 1'b0, 1'b0, 1'b1);
    mem_log.delete();
    fork
      host_acc(13'h0456, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
      begin repeat (3) @(negedge clk); cpu_acc(13'h1FFF, 1'b0, 16'h0, 1'b0); end
    join
    chk(mem_log.size() == 2, "R8", "one array request per access", 32'(mem_log.size()), 2);
    chk(mem_log[0] == 13'h1FFF, "R7", "cpu first after host grant", 32'(mem_log[0]), 32'h1FFF);

    // shared cell: cpu writes, host reads back
    cpu_acc(13'h0777, 1'b1, 16'h6C3E, 1'b1);
    host_acc(13'h0777, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(hq.size() == 0 && cq.size() == 0, "R5", "all expected results seen",
        32'(hq.size() + cq.size()), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule